// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services translation misses. When the translation buffer cannot find a virtual page number, it hands that number to the walker. The walker then reads two dependent page-table entries from physical memory. The page tables sit in untranslated physical memory, so the walker's own reads need no translation.

The first read uses the root table base, which is sampled from the processor's root register at the moment the request is taken. It returns a pointer to a second-level table. The second read returns the physical page number and the permission bits of the data page. Either read can end the walk early with a page-fault result: an entry that marks a page as nonexistent or as not resident stops the walk, and no translation is delivered.

Memory is reached through a request/response read port. A request is held until the memory accepts it, and one response is expected for each accepted request.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: The first read goes to address `{root_ppn,12'h000} + 4*vpn[19:10]`. `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is seen.
- R3: The second read goes to address `{entry1[31:12],12'h000} + 4*vpn[9:0]`, where entry1 is the first-level entry.
- R4: A walk that succeeds raises `res_valid` for exactly one cycle with `res_fault`=0. It gives `res_ppn` = entry2[31:12] and `res_perm` = entry2[4:2], where bit 2 is read, bit 3 is write and bit 4 is execute.
- R5: An entry is usable only when bit 0 (valid) and bit 1 (resident) are both 1. An unusable first-level entry ends the walk with `res_fault`=1 and `res_level`=0, and no second read is issued.
- R6: An unusable second-level entry ends the walk with `res_fault`=1 and `res_level`=1.
- R7: A request is accepted only while idle. While a walk is in progress, `req_ready` is 0 and a presented request starts no walk and produces no result.
- R8: `root_ppn` is sampled when a request is accepted. Changing it during a walk does not affect that walk.
- R9: A memory response is used only while the walker waits for one. A response presented while a read request is still pending is ignored.
- R10: `res_vpn` returns the virtual page number of the walk that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_vpn | input | 20 | Virtual page number to translate |
| req_ready | output | 1 | Walker idle; request taken this cycle |
| root_ppn | input | 20 | Page number of the first-level table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Physical byte address of the entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Walk result, one cycle |
| res_fault | output | 1 | Result is a page fault |
| res_level | output | 1 | Faulting level: 0 first, 1 second |
| res_vpn | output | 20 | Virtual page number of the result |
| res_ppn | output | 20 | Physical page number on success |
| res_perm | output | 3 | Execute/write/read bits on success |

## Verification
Two things can happen in the same cycle: a result is delivered, and the next miss request is presented. The bench holds the next request valid from the start of a walk until after the result, so it is still present in the cycle the result leaves. It then checks that the held request is taken only once the walker is idle again. It also checks that the new walk's first address follows the previous result, and that the results come out in request order. A second overlap is a memory response that arrives while a read request is still stalled. The bench injects a faulting entry at such moments and checks that the walk still returns the result predicted from the real table contents.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W  = 10,
  parameter int OFS_W  = 12,
  parameter int PA_W   = 32,
  parameter int PERM_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [2*IDX_W-1:0]      req_vpn,
  output logic                    req_ready,
  input  logic [PA_W-OFS_W-1:0]   root_ppn,
  output logic                    mem_req_valid,
  output logic [PA_W-1:0]         mem_req_addr,
  input  logic                    mem_req_ready,
  input  logic                    mem_rsp_valid,
  input  logic [PA_W-1:0]         mem_rsp_data,
  output logic                    res_valid,
  output logic                    res_fault,
  output logic                    res_level,
  output logic [2*IDX_W-1:0]      res_vpn,
  output logic [PA_W-OFS_W-1:0]   res_ppn,
  output logic [PERM_W-1:0]       res_perm
);
  localparam int VPN_W = 2 * IDX_W;
  localparam int PPN_W = PA_W - OFS_W;

  typedef enum logic [2:0] {IDLE, READ_L1, WAIT_L1, READ_L2, WAIT_L2, DONE, FAULT} st_t;
  st_t st;

  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] root_q, base_q, ppn_q;
  logic [PERM_W-1:0] perm_q;
  logic lvl_q;

  wire usable = mem_rsp_data[0] & mem_rsp_data[1];
  wire [IDX_W-1:0] idx_hi = vpn_q[VPN_W-1 -: IDX_W];
  wire [IDX_W-1:0] idx_lo = vpn_q[IDX_W-1:0];
  wire [PA_W-1:0] off_hi = PA_W'(idx_hi) << 2;
  wire [PA_W-1:0] off_lo = PA_W'(idx_lo) << 2;

  assign req_ready     = (st == IDLE);
  assign mem_req_valid = (st == READ_L1) || (st == READ_L2);
  assign mem_req_addr  = (st == READ_L2) ? ({base_q, OFS_W'(0)} + off_lo)
                                         : ({root_q, OFS_W'(0)} + off_hi);
  assign res_valid = (st == DONE) || (st == FAULT);
  assign res_fault = (st == FAULT);
  assign res_level = lvl_q;
  assign res_vpn   = vpn_q;
  assign res_ppn   = ppn_q;
  assign res_perm  = perm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      vpn_q <= '0;
      root_q <= '0;
      base_q <= '0;
      ppn_q <= '0;
      perm_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          vpn_q  <= req_vpn;
          root_q <= root_ppn;
          ppn_q  <= '0;
          perm_q <= '0;
          lvl_q  <= 1'b0;
          st     <= READ_L1;
        end
        READ_L1: if (mem_req_ready) st <= WAIT_L1;
        WAIT_L1: if (mem_rsp_valid) begin
          if (usable) begin
            base_q <= mem_rsp_data[PA_W-1 -: PPN_W];
            st     <= READ_L2;
          end else begin
            lvl_q <= 1'b0;
            st    <= FAULT;
          end
        end
        READ_L2: if (mem_req_ready) st <= WAIT_L2;
        WAIT_L2: if (mem_rsp_valid) begin
          if (usable) begin
            ppn_q  <= mem_rsp_data[PA_W-1 -: PPN_W];
            perm_q <= mem_rsp_data[2 +: PERM_W];
            st     <= DONE;
          end else begin
            lvl_q <= 1'b1;
            st    <= FAULT;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_one_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_ppn_from_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT_L2) && mem_rsp_valid && usable |=>
      res_valid && !res_fault && res_ppn == $past(mem_rsp_data[PA_W-1 -: PPN_W]));

  p_l1_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT_L1) && mem_rsp_valid && !usable |=> res_valid && res_fault && !res_level);

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !res_valid);

  p_rsp_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid);
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [19:0] req_vpn = '0, root_ppn = '0;
  logic [31:0] mem_rsp_data = '0;
  logic req_ready, mem_req_valid, res_valid, res_fault, res_level;
  logic [31:0] mem_req_addr;
  logic [19:0] res_vpn, res_ppn;
  logic [2:0] res_perm;

  pt_walker u0 (.clk, .rst_n, .req_valid, .req_vpn, .req_ready, .root_ppn,
    .mem_req_valid, .mem_req_addr, .mem_req_ready, .mem_rsp_valid, .mem_rsp_data,
    .res_valid, .res_fault, .res_level, .res_vpn, .res_ppn, .res_perm);

  int n_chk = 0, n_bad = 0;
  bit [31:0] pmem [bit [31:0]];
  logic [31:0] q_addr[$];
  logic q_fault[$], q_lvl[$];
  logic [19:0] q_vpn[$], q_ppn[$];
  logic [2:0] q_perm[$];
  bit spur_en = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] rd(bit [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  function automatic bit [31:0] ent(bit [19:0] pn, bit [2:0] perm, bit v, bit r);
    return {pn, 7'h0, perm, r, v};
  endfunction

  task automatic push_exp(logic [19:0] root, logic [19:0] vpn);
    bit [31:0] a1, e1, a2, e2;
    a1 = {root, 12'h0} + {20'h0, vpn[19:10], 2'b00};
    e1 = rd(a1);
    q_addr.push_back(a1);
    q_vpn.push_back(vpn);
    if (!(e1[0] && e1[1])) begin
      q_fault.push_back(1); q_lvl.push_back(0); q_ppn.push_back(0); q_perm.push_back(0);
      return;
    end
    a2 = {e1[31:12], 12'h0} + {20'h0, vpn[9:0], 2'b00};
    e2 = rd(a2);
    q_addr.push_back(a2);
    if (!(e2[0] && e2[1])) begin
      q_fault.push_back(1); q_lvl.push_back(1); q_ppn.push_back(0); q_perm.push_back(0);
    end else begin
      q_fault.push_back(0); q_lvl.push_back(0); q_ppn.push_back(e2[31:12]); q_perm.push_back(e2[4:2]);
    end
  endtask

  // memory responder and address monitor
  int cyc = 0;
  initial begin
    bit pend = 0; int cnt = 0; bit [31:0] pa = 0; logic [31:0] ea;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 0;
      if (pend) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = rd(pa); pend = 0;
        end
      end
      mem_req_ready = (cyc % 3 != 1);
      if (rst_n && mem_req_valid) begin
        chk(!req_ready, "R7 busy while reading", {31'h0, req_ready}, 32'h0);
        if (!mem_req_ready && spur_en && !mem_rsp_valid) begin
          mem_rsp_valid = 1; mem_rsp_data = 32'h0;
        end
        if (mem_req_ready) begin
          ea = (q_addr.size() != 0) ? q_addr.pop_front() : 32'hxxxxxxxx;
          chk(mem_req_addr === ea, "R2/R3/R5 read address", mem_req_addr, ea);
          pa = mem_req_addr; pend = 1; cnt = 2;
        end
      end
    end
  end

  // result monitor (scoreboard)
  initial forever begin
    @(negedge clk);
    if (rst_n && res_valid) begin
      if (q_vpn.size() == 0) chk(0, "R7 unexpected result", {12'h0, res_vpn}, 32'h0);
      else begin
        logic f, l; logic [19:0] v, p; logic [2:0] m;
        f = q_fault.pop_front(); l = q_lvl.pop_front(); v = q_vpn.pop_front();
        p = q_ppn.pop_front(); m = q_perm.pop_front();
        chk(res_vpn == v, "R10 vpn", {12'h0, res_vpn}, {12'h0, v});
        chk(res_fault == f, "R4/R5/R6 fault", {31'h0, res_fault}, {31'h0, f});
        if (f) chk(res_level == l, "R5/R6 level", {31'h0, res_level}, {31'h0, l});
        else begin
          chk(res_ppn == p, "R4 ppn", {12'h0, res_ppn}, {12'h0, p});
          chk(res_perm == m, "R4 perm", {29'h0, res_perm}, {29'h0, m});
        end
      end
      @(negedge clk);
      chk(!res_valid, "R4 single-cycle result", {31'h0, res_valid}, 32'h0);
    end
  end

  task automatic walk(logic [19:0] root, logic [19:0] vpn, bit spur, bit intrude, bit chroot);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    root_ppn = root; req_vpn = vpn; req_valid = 1; spur_en = spur;
    push_exp(root, vpn);
    @(negedge clk);
    req_valid = 0;
    if (chroot) root_ppn = root ^ 20'h00F00;   // R8
    if (intrude) begin                           // R7
      req_valid = 1; req_vpn = ~vpn;
      chk(!req_ready, "R7 request while busy", {31'h0, req_ready}, 32'h0);
      @(negedge clk); @(negedge clk);
      req_valid = 0;
    end
    while (q_vpn.size() != 0) @(negedge clk);
    spur_en = 0;
  endtask

  initial begin
    pmem[32'h0010_0004] = ent(20'h00200, 3'b000, 1, 1);
    pmem[32'h0010_0008] = ent(20'h00700, 3'b000, 0, 1);
    pmem[32'h0010_000C] = ent(20'h00800, 3'b000, 1, 0);
    pmem[32'h0010_0FFC] = ent(20'h00300, 3'b000, 1, 1);
    pmem[32'h0020_000C] = ent(20'hABCDE, 3'b101, 1, 1);
    pmem[32'h0020_0014] = ent(20'h12345, 3'b011, 1, 0);
    pmem[32'h0020_0018] = ent(20'h54321, 3'b111, 0, 1);
    pmem[32'h0020_001C] = ent(20'h0F0F0, 3'b010, 1, 1);
    pmem[32'h0030_0FFC] = ent(20'hFFFFF, 3'b111, 1, 1);
    pmem[32'h0050_0004] = ent(20'h00600, 3'b000, 1, 1);
    pmem[32'h0060_000C] = ent(20'h24680, 3'b001, 1, 1);
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b0 || req_ready === 1'b1, "R1 ready defined", {31'h0, req_ready}, 32'h1);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !res_valid, "R1 reset state",
        {29'h0, req_ready, mem_req_valid, res_valid}, 32'h4);
    walk(20'h00100, {10'd1, 10'd3}, 0, 0, 0);       // R4 success
    walk(20'h00100, {10'd2, 10'd0}, 0, 0, 0);       // R5 invalid L1
    walk(20'h00100, {10'd3, 10'd9}, 0, 0, 0);       // R5 non-resident L1
    walk(20'h00100, {10'd1, 10'd5}, 0, 0, 0);       // R6 non-resident L2
    walk(20'h00100, {10'd1, 10'd6}, 0, 0, 0);       // R6 invalid L2
    walk(20'h00100, {10'h3FF, 10'h3FF}, 0, 0, 0);   // R2 R3 top indices
    walk(20'h00100, {10'd1, 10'd7}, 1, 0, 0);       // R9 stray responses
    walk(20'h00100, {10'd1, 10'd3}, 0, 1, 0);       // R7 intruding request
    walk(20'h00500, {10'd1, 10'd3}, 0, 0, 1);       // R8 root changed mid-walk
    // back-to-back: next request held through the result cycle (R7)
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    root_ppn = 20'h00100; req_vpn = {10'd1, 10'd3}; req_valid = 1;
    push_exp(20'h00100, {10'd1, 10'd3});
    @(negedge clk);
    req_vpn = {10'd1, 10'd7};
    push_exp(20'h00100, {10'd1, 10'd7});
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (q_vpn.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(req_ready && !res_valid, "R1 idle at end", {30'h0, req_ready, res_valid}, 32'h2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule